// File: doc/BRIEF.md
# Pseudo-Static RAM Row-Refresh Arbiter

This block is the on-die refresh control of a memory built from DRAM cells that is presented to the system as a static RAM. It decides which row the array activates next, and why. An activate can come from a normal access cycle, where the row is taken from the external address. It can also come from a refresh, where the row is taken from an internal 9-bit refresh counter that advances after every counter-addressed refresh. Each pulse on `row_act` stands for one row activation.

A single active-low refresh pin selects between two refresh modes. When the pin falls, one counter-addressed refresh is requested. If the pin then stays low for `SELF_THRESH` clock samples in a row, the block enters self-refresh. In self-refresh an internal timer requests one counter-addressed refresh every `SELF_PERIOD` clocks, and this continues until the pin goes high. Refresh requests never interrupt an access. They are queued, and they are granted only once chip enable has been high for a recovery delay. The default timing parameters are computed from the clock period:
- The self-refresh interval is 8 ms / 512, rounded down to whole clocks.
- The self-refresh threshold is 8 µs, rounded up to whole clocks.
- The recovery delay is 30 ns, rounded up to whole clocks.

All inputs are synchronous to `clk`. No data path passes through the block, so every pin is plain control with no valid/ready handshake.

Top module: `psram_refresh_arb`

## Requirements
- R1: After reset `row_act` and `busy` are 0, and the first counter-addressed refresh uses row 0.
- R2: If the refresh pin is first sampled low at clock edge E while chip enable is high and idle, `row_act` is 1 for exactly one cycle after edge E+1. In that cycle `row_sel` holds the refresh counter value, and the counter then advances by one.
- R3: The refresh counter is `ROW_W` = 9 bits wide and wraps from 511 to 0, so refreshes visit rows in the order 0, 1, …, 511, 0, 1, ….
- R4: If chip enable (active low) is first sampled low at edge E, `row_act` is 1 for one cycle after E. In that cycle `row_sel` equals bits [8:0] of the address sampled at E. Address bits [16:9] and later address changes within the access have no effect.
- R5: A refresh request that arrives while chip enable is low produces no activate during the access. Suppose chip enable is first sampled high again at edge E. The held refresh is then issued after edge E+`RECOVER`+1.
- R6: Up to `PEND_MAX` refresh requests are queued without loss. They are issued on consecutive cycles, in counter order, once the grant condition holds.
- R7: Self-refresh is entered when the refresh pin is sampled low on `SELF_THRESH` consecutive edges, the last of these being edge Es. Timer refreshes then appear after edges Es+`SELF_PERIOD`+1, Es+2·`SELF_PERIOD`+1, and so on. These are in addition to the single refresh from the falling edge. The mode is left at the first edge where the pin is sampled high, and no further timer refreshes follow.
- R8: `busy` is 1 whenever any of the following holds: chip enable was sampled low on the last edge, a refresh is queued, the recovery delay is running, or self-refresh is active. Otherwise `busy` is 0.
- R9: Leaving self-refresh does not change the refresh counter. The next counter-addressed refresh continues from the row after the last one issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chip_en_n | input | 1 | Active-low chip enable; a falling edge starts an access cycle |
| rfsh_n | input | 1 | Active-low refresh request pin (pulse or hold) |
| row_addr_in | input | ADDR_W (17) | External address; low `ROW_W` bits select the row |
| row_sel | output | ROW_W (9) | Row address of the current activate |
| row_act | output | 1 | One-cycle row-activate strobe |
| busy | output | 1 | Block is in an access, has queued refreshes, is recovering, or is in self-refresh |

## Verification
Isolated refresh pulses are swept past a full counter wrap. This shows the counter order and the 511-to-0 wrap, and it shows that access rows are not used in place of counter rows. Accesses use addresses that differ only in the upper bits and addresses that change during the cycle. These separate correct use of the low nine bits from any leakage of the upper bits. Refresh pulses issued during a long access, first singly and then three at a time, show the difference between holding and dropping a request, and they pin the grant cycle to the end of the recovery delay. One long low hold on the refresh pin is then tracked cycle by cycle through entry, timer ticks and exit. After it, one more pulse shows that the counter resumes without a gap.

// File: rtl/psram_rfsh_pkg.sv
package psram_rfsh_pkg;

  // Whole clock cycles that fit in an interval (rounded down).
  function automatic int unsigned cyc_floor(input longint unsigned span_ps,
                                            input longint unsigned clk_ps);
    return int'(span_ps / clk_ps);
  endfunction

  // Clock cycles needed to cover an interval (rounded up).
  function automatic int unsigned cyc_ceil(input longint unsigned span_ps,
                                           input longint unsigned clk_ps);
    return int'((span_ps + clk_ps - 1) / clk_ps);
  endfunction

  // Array refresh budget: all rows within this window.
  localparam longint unsigned RETENTION_PS   = 64'd8_000_000_000;
  // Low time on the refresh pin that hands refresh to the timer.
  localparam longint unsigned SELF_ENTRY_PS  = 64'd8_000_000;
  // Quiet time after chip enable rises before a refresh may start.
  localparam longint unsigned CE_RECOVER_PS  = 64'd30_000;

endpackage

// File: rtl/rfsh_mode_detect.sv
module rfsh_mode_detect #(
  parameter int unsigned SELF_THRESH = 1000,
  parameter int unsigned SELF_PERIOD = 1953
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rfsh_n,
  output logic strobe_req,
  output logic tick,
  output logic self_mode
);
  localparam int unsigned LOW_W = $clog2(SELF_THRESH + 2);
  localparam int unsigned TMR_W = $clog2(SELF_PERIOD + 2);

  logic             rf_q;
  logic [LOW_W-1:0] low_cnt;
  logic [TMR_W-1:0] tmr;

  // Falling edge of the pin: one counter-addressed refresh.
  assign strobe_req = rf_q & ~rfsh_n;
  // Timer expiry while self-refresh is active.
  assign tick = self_mode && (tmr == TMR_W'(SELF_PERIOD - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rf_q      <= 1'b1;
      low_cnt   <= '0;
      self_mode <= 1'b0;
      tmr       <= '0;
    end else begin
      rf_q <= rfsh_n;
      if (rfsh_n) begin
        low_cnt   <= '0;
        self_mode <= 1'b0;
      end else begin
        if (low_cnt != LOW_W'(SELF_THRESH))
          low_cnt <= low_cnt + LOW_W'(1);
        if (low_cnt == LOW_W'(SELF_THRESH - 1))
          self_mode <= 1'b1;
      end
      if (!self_mode || tick)
        tmr <= '0;
      else
        tmr <= tmr + TMR_W'(1);
    end
  end

endmodule

// File: rtl/rfsh_row_counter.sv
module rfsh_row_counter #(
  parameter int unsigned ROW_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  output logic [ROW_W-1:0] row_cnt
);
  // Natural binary wrap covers the full row range.
  always_ff @(posedge clk) begin
    if (!rst_n)
      row_cnt <= '0;
    else if (advance)
      row_cnt <= row_cnt + ROW_W'(1);
  end

endmodule

// File: rtl/rfsh_arbiter.sv
module rfsh_arbiter #(
  parameter int unsigned ROW_W    = 9,
  parameter int unsigned RECOVER  = 4,
  parameter int unsigned PEND_MAX = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chip_en_n,
  input  logic [ROW_W-1:0] row_addr_lo,
  input  logic             strobe_req,
  input  logic             tick,
  input  logic             self_mode,
  input  logic [ROW_W-1:0] row_cnt,
  output logic             grant,
  output logic             access_start,
  output logic [ROW_W-1:0] row_sel,
  output logic             row_act,
  output logic             busy
);
  localparam int unsigned REC_W  = $clog2(RECOVER + 2);
  localparam int unsigned PEND_W = $clog2(PEND_MAX + 2);

  logic              ce_q;
  logic              ce_rise;
  logic              add_req;
  logic [REC_W-1:0]  rec_q;
  logic [PEND_W-1:0] pend_q;

  assign access_start = ce_q & ~chip_en_n;
  assign ce_rise      = ~ce_q & chip_en_n;
  assign add_req      = strobe_req | tick;
  assign grant        = (pend_q != '0) && chip_en_n && ce_q && (rec_q == '0);
  assign busy         = ~ce_q | (pend_q != '0) | (rec_q != '0) | self_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ce_q    <= 1'b1;
      rec_q   <= '0;
      pend_q  <= '0;
      row_act <= 1'b0;
      row_sel <= '0;
    end else begin
      ce_q <= chip_en_n;

      if (ce_rise)
        rec_q <= REC_W'(RECOVER);
      else if (rec_q != '0)
        rec_q <= rec_q - REC_W'(1);

      if (add_req && !grant && pend_q != PEND_W'(PEND_MAX))
        pend_q <= pend_q + PEND_W'(1);
      else if (grant && !add_req)
        pend_q <= pend_q - PEND_W'(1);

      row_act <= access_start | grant;
      if (access_start)
        row_sel <= row_addr_lo;
      else if (grant)
        row_sel <= row_cnt;
    end
  end

endmodule

// File: rtl/psram_refresh_arb.sv
module psram_refresh_arb
  import psram_rfsh_pkg::*;
#(
  parameter int unsigned CLK_PS      = 8000,
  parameter int unsigned ROW_W       = 9,
  parameter int unsigned ADDR_W      = 17,
  parameter int unsigned PEND_MAX    = 4,
  parameter int unsigned SELF_PERIOD = cyc_floor(RETENTION_PS / 512, CLK_PS),
  parameter int unsigned SELF_THRESH = cyc_ceil(SELF_ENTRY_PS, CLK_PS),
  parameter int unsigned RECOVER     = cyc_ceil(CE_RECOVER_PS, CLK_PS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_en_n,
  input  logic              rfsh_n,
  input  logic [ADDR_W-1:0] row_addr_in,
  output logic [ROW_W-1:0]  row_sel,
  output logic              row_act,
  output logic              busy
);
  logic             strobe_req;
  logic             tick;
  logic             self_mode;
  logic             grant;
  logic             access_start;
  logic [ROW_W-1:0] row_cnt;
  logic             unused_addr_hi;

  generate
    if (ADDR_W > ROW_W) begin : g_hi
      assign unused_addr_hi = ^row_addr_in[ADDR_W-1:ROW_W];
    end else begin : g_nohi
      assign unused_addr_hi = 1'b0;
    end
  endgenerate

  rfsh_mode_detect #(
    .SELF_THRESH(SELF_THRESH),
    .SELF_PERIOD(SELF_PERIOD)
  ) u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .rfsh_n    (rfsh_n),
    .strobe_req(strobe_req),
    .tick      (tick),
    .self_mode (self_mode)
  );

  rfsh_row_counter #(.ROW_W(ROW_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .advance(grant),
    .row_cnt(row_cnt)
  );

  rfsh_arbiter #(
    .ROW_W   (ROW_W),
    .RECOVER (RECOVER),
    .PEND_MAX(PEND_MAX)
  ) u_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .chip_en_n   (chip_en_n),
    .row_addr_lo (row_addr_in[ROW_W-1:0]),
    .strobe_req  (strobe_req),
    .tick        (tick),
    .self_mode   (self_mode),
    .row_cnt     (row_cnt),
    .grant       (grant),
    .access_start(access_start),
    .row_sel     (row_sel),
    .row_act     (row_act),
    .busy        (busy)
  );

endmodule

// File: rtl/psram_rfsh_checker.sv
module psram_rfsh_checker #(
  parameter int unsigned ROW_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             chip_en_n,
  input logic             rfsh_n,
  input logic [ROW_W-1:0] addr_lo,
  input logic [ROW_W-1:0] row_sel,
  input logic             row_act,
  input logic             grant,
  input logic [ROW_W-1:0] row_cnt,
  input logic             self_mode
);

  assert_access_row_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(chip_en_n) |=> (row_act && row_sel == $past(addr_lo)));

  assert_hold_in_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!chip_en_n && !$past(chip_en_n)) |=> !row_act);

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> (row_cnt == ROW_W'($past(row_cnt) + 1'b1)));

  assert_count_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && row_cnt == '1) |=> (row_cnt == '0));

  assert_self_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_n |=> !self_mode);

endmodule

bind psram_refresh_arb psram_rfsh_checker #(.ROW_W(ROW_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .chip_en_n(chip_en_n),
  .rfsh_n   (rfsh_n),
  .addr_lo  (row_addr_in[ROW_W-1:0]),
  .row_sel  (row_sel),
  .row_act  (row_act),
  .grant    (grant),
  .row_cnt  (row_cnt),
  .self_mode(self_mode)
);

// File: tb/tb_psram_refresh_arb.sv
`timescale 1ns/1ps
module tb_psram_refresh_arb;
  localparam int unsigned ROW_W = 9, ADDR_W = 17;
  localparam int unsigned THR = 20, PER = 10, REC = 3, PMAX = 4;

  logic clk = 1'b0, rst_n = 1'b0, chip_en_n = 1'b1, rfsh_n = 1'b1;
  logic [ADDR_W-1:0] row_addr_in = '0;
  logic [ROW_W-1:0]  row_sel;
  logic              row_act, busy;
  logic [ROW_W-1:0]  exp_row = '0;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  psram_refresh_arb #(
    .ROW_W(ROW_W), .ADDR_W(ADDR_W), .PEND_MAX(PMAX),
    .SELF_PERIOD(PER), .SELF_THRESH(THR), .RECOVER(REC)
  ) dut (
    .clk(clk), .rst_n(rst_n), .chip_en_n(chip_en_n), .rfsh_n(rfsh_n),
    .row_addr_in(row_addr_in), .row_sel(row_sel), .row_act(row_act), .busy(busy)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse(input string req);
    @(negedge clk) rfsh_n = 1'b0;
    @(negedge clk) rfsh_n = 1'b1; chk(req, row_act, 0);
    @(negedge clk) chk(req, row_act, 1); chk(req, row_sel, exp_row); exp_row++;
    @(negedge clk) chk(req, row_act, 0);
  endtask

  task automatic access(input logic [ADDR_W-1:0] a);
    @(negedge clk) begin chip_en_n = 1'b0; row_addr_in = a; end
    @(negedge clk) chk("R4 act", row_act, 1); chk("R4 row", row_sel, a[ROW_W-1:0]);
    chk("R8 busy in access", busy, 1);
    row_addr_in = ~a;
    @(negedge clk) chk("R4 single act", row_act, 0);
    @(negedge clk) chk("R4 late addr ignored", row_sel, a[ROW_W-1:0]);
    chip_en_n = 1'b1;
    repeat (REC + 2) @(negedge clk);
  endtask

  task automatic held_refresh(input int n, input string req);
    @(negedge clk) chip_en_n = 1'b0;
    @(negedge clk);
    for (int j = 0; j < n; j++) begin
      @(negedge clk) rfsh_n = 1'b0;
      @(negedge clk) rfsh_n = 1'b1; chk(req, row_act, 0);
    end
    @(negedge clk) chk(req, row_act, 0); chk("R8 busy queued", busy, 1);
    chip_en_n = 1'b1;
    for (int k = 0; k <= REC + n; k++) begin
      @(negedge clk);
      chk(req, row_act, (k >= REC + 1) ? 1 : 0);
      if (k >= REC + 1) begin chk(req, row_sel, exp_row); exp_row++; end
    end
    @(negedge clk) chk(req, row_act, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 act", row_act, 0); chk("R1 busy", busy, 0);
    pulse("R1 first row / R2");
    pulse("R2 second row");
    for (int i = 0; i < 515; i++) pulse("R3 sweep");
    access(17'h1_FE05);
    access(17'h0_0005);
    for (int i = 0; i < 6; i++) access(ADDR_W'(i * 32'h4A3B + 32'h1_0100));
    held_refresh(1, "R5 held");
    held_refresh(3, "R6 queue");
    @(negedge clk) chk("R8 idle busy", busy, 0);
    @(negedge clk) rfsh_n = 1'b0;
    for (int k = 1; k <= 85; k++) begin
      @(negedge clk);
      chk("R7 self act", row_act,
          (k == 2 || (k >= THR + PER + 1 && k <= 55 && (k - THR - PER - 1) % PER == 0)) ? 1 : 0);
      if (row_act) begin chk("R7 self row", row_sel, exp_row); exp_row++; end
      if (k == 25) chk("R8 busy self", busy, 1);
      if (k == 55) rfsh_n = 1'b1;
    end
    pulse("R9 counter resumes");
    @(negedge clk) chk("R8 final busy", busy, 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule